// File: doc/BRIEF.md
# Channel Address Interleave Remover

This block turns a system physical address into the address seen by a single memory channel. A request gives the system address, the memory controller that owns it and the channel within that controller. The block finds the target rule that covers the address, subtracts the channel's offset for that rule, and then strips the socket and channel interleave. The result is a dense channel-local address, reported together with the socket and channel way counts of the matching rule.

Software loads the rule tables through a simple write port before any request is issued. Each controller has eight rules. A rule consists of a base word and a wayness word, plus one offset word for each channel. A request is started with a one-cycle `start` pulse. `busy` is high while the request is in progress. Completion is signalled by a one-cycle `done` pulse, and `miss` flags an address that no rule covers. Removing a three-way channel interleave requires a true division by three. A bit-serial divider performs it, so such requests take longer than requests whose way counts are powers of two.

Top module: `chan_ilv_remover`

## Requirements
- R1: Configuration write. A write happens when `cfg_we` is high. `cfg_kind` selects the target: 0 writes the base word of rule `cfg_rule` of controller `cfg_ctrl`, 1 writes that rule's wayness word, and 2 writes that rule's offset word for channel `cfg_chan`. Kind 3 has no effect. A kind-2 write with `cfg_chan` of 3 or more also has no effect.
- R2: Rule matching. Rule i covers the addresses from base[31:12]·2^26 up to and including wayness[31:12]·2^26 + 2^26−1. The covering rule with the lowest index is chosen.
- R3: Miss. If no rule of the selected controller covers the address, `done` and `miss` rise one clock edge after the edge that samples `start`. In that case `chan_addr`, `skt_ways` and `chn_ways` read 0.
- R4: Way counts. `skt_ways` = 2^wayness[11:10] and `chn_ways` = wayness[9:8]+1, both taken from the matching rule.
- R5: Granularity. Base bits [5:4] give the socket interleave bit and base bits [7:6] give the channel interleave bit. Codes 0, 1, 2 and 3 map to bit positions 6, 8, 12 and 30.
- R6: Offset. The offset word of the matching rule, for the requested controller and channel, gives offset[23:4]·2^26. This value is subtracted from the address modulo 2^46 before any interleave is removed.
- R7: Channel-first order. This order applies when the channel way count is 3 and the socket bit is above the channel bit. The channel step runs first and the socket step second. A step with bit s and way count w maps a to ((a>>s)/w)<<s, with the low s bits taken from the step's own input.
- R8: Socket-first order. In every other case the socket step runs first and the channel step second. Both steps take their low s bits from the original system address.
- R9: Handshake. `start` is accepted only while `busy` is low. `done` is a single-cycle pulse on the cycle where `busy` falls. On a hit, `done` rises 3 edges after the start edge, or 49 edges when the channel way count is 3. A `start` that arrives while busy is ignored.
- R10: Each controller uses only its own rules and offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 base, 1 wayness, 2 offset, 3 none |
| cfg_ctrl | input | 1 | Controller index of the write |
| cfg_chan | input | 2 | Channel index for offset writes |
| cfg_rule | input | 3 | Rule index of the write |
| cfg_data | input | 32 | Write data |
| start | input | 1 | Request pulse |
| sys_addr | input | 46 | System address |
| ctrl_sel | input | 1 | Controller owning the address |
| chan_sel | input | 2 | Channel owning the address |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| miss | output | 1 | No rule covered the address |
| chan_addr | output | 46 | Channel-local address |
| skt_ways | output | 4 | Socket way count |
| chn_ways | output | 3 | Channel way count |

## Verification
A wrong internal state shows up in different ways depending on where it sits. A corrupted step counter or a stuck divider moves the cycle on which `done` arrives, or leaves `busy` high. The bench compares `done` and `busy` with the model on every clock, so such a fault is seen within one cycle of the expected completion. A wrong rule selection, order flag or latched offset only shows up in `chan_addr` or the way counts at completion. For that reason the stimulus includes rule overlaps, exact rule boundaries, offset wrap-around, both step orders, and a `start` pulse issued mid-request.

// File: rtl/chan_ilv_remover.sv
`timescale 1ns/1ps
module chan_ilv_remover #(
  parameter int AW    = 46,
  parameter int NRULE = 8,
  parameter int NCTRL = 2,
  parameter int NCHAN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_kind,
  input  logic          cfg_ctrl,
  input  logic [1:0]    cfg_chan,
  input  logic [2:0]    cfg_rule,
  input  logic [31:0]   cfg_data,
  input  logic          start,
  input  logic [AW-1:0] sys_addr,
  input  logic          ctrl_sel,
  input  logic [1:0]    chan_sel,
  output logic          busy,
  output logic          done,
  output logic          miss,
  output logic [AW-1:0] chan_addr,
  output logic [3:0]    skt_ways,
  output logic [2:0]    chn_ways
);
  localparam int LSH = AW - 20;
  localparam int RW  = $clog2(NRULE);
  localparam int NW  = $clog2(AW);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_STEP, S_DIV} st_t;
  st_t state;

  logic [31:0] base_m [NCTRL][NRULE];
  logic [31:0] way_m  [NCTRL][NRULE];
  logic [31:0] ofs_m  [NCTRL][NCHAN][NRULE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_m <= '{default: '0};
      way_m  <= '{default: '0};
      ofs_m  <= '{default: '0};
    end else if (cfg_we) begin
      case (cfg_kind)
        2'd0: base_m[cfg_ctrl][cfg_rule] <= cfg_data;
        2'd1: way_m[cfg_ctrl][cfg_rule]  <= cfg_data;
        2'd2: if (int'(cfg_chan) < NCHAN) ofs_m[cfg_ctrl][cfg_chan][cfg_rule] <= cfg_data;
        default: ;
      endcase
    end
  end

  function automatic logic [4:0] gbit(input logic [1:0] g);
    case (g)
      2'd0: return 5'd6;
      2'd1: return 5'd8;
      2'd2: return 5'd12;
      default: return 5'd30;
    endcase
  endfunction

  logic [AW-1:0] addr_r, diff_r, acc_r, dv_r;
  logic          ctrl_r, chfirst_r, step_r;
  logic [1:0]    chan_r, slog_r, cw_r, rm_r;
  logic [4:0]    sbit_r, cbit_r;
  logic [NW-1:0] cnt_r;

  logic          hit;
  logic [RW-1:0] sel;
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if ({base_m[ctrl_r][RW'(i)][31:12], {LSH{1'b0}}} <= addr_r &&
          addr_r <= {way_m[ctrl_r][RW'(i)][31:12], {LSH{1'b1}}}) begin
        hit = 1'b1;
        sel = RW'(i);
      end
    end
  end

  wire [31:0] b_sel = base_m[ctrl_r][sel];
  wire [31:0] w_sel = way_m[ctrl_r][sel];
  wire [31:0] o_sel = (int'(chan_r) < NCHAN) ? ofs_m[ctrl_r][chan_r][sel] : 32'd0;

  wire           isch   = chfirst_r ^ step_r;
  wire [AW-1:0]  op_a   = step_r ? acc_r : diff_r;
  wire [4:0]     s      = isch ? cbit_r : sbit_r;
  wire [AW-1:0]  low    = chfirst_r ? op_a : addr_r;
  wire           use_div = isch && (cw_r == 2'd2);
  wire [1:0]     k      = isch ? ((cw_r == 2'd3) ? 2'd2 : cw_r) : slog_r;
  wire [AW-1:0]  shr    = op_a >> s;
  wire [AW-1:0]  lowm   = low & ~({AW{1'b1}} << s);
  wire [AW-1:0]  pow_res = ((shr >> k) << s) | lowm;

  wire [2:0]     dt     = {rm_r, dv_r[AW-1]};
  wire           dbit   = dt >= 3'd3;
  wire [1:0]     drm    = dbit ? 2'(dt - 3'd3) : dt[1:0];
  wire [AW-1:0]  div_q  = {dv_r[AW-2:0], dbit};
  wire [AW-1:0]  div_res = (div_q << s) | lowm;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done <= 1'b0; miss <= 1'b0;
      chan_addr <= '0; skt_ways <= '0; chn_ways <= '0;
      addr_r <= '0; diff_r <= '0; acc_r <= '0; dv_r <= '0;
      ctrl_r <= 1'b0; chan_r <= '0; chfirst_r <= 1'b0; step_r <= 1'b0;
      slog_r <= '0; cw_r <= '0; rm_r <= '0; sbit_r <= '0; cbit_r <= '0; cnt_r <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          addr_r <= sys_addr;
          ctrl_r <= ctrl_sel;
          chan_r <= chan_sel;
          state  <= S_SCAN;
        end
        S_SCAN: if (!hit) begin
          done <= 1'b1; miss <= 1'b1;
          chan_addr <= '0; skt_ways <= '0; chn_ways <= '0;
          state <= S_IDLE;
        end else begin
          miss      <= 1'b0;
          sbit_r    <= gbit(b_sel[5:4]);
          cbit_r    <= gbit(b_sel[7:6]);
          slog_r    <= w_sel[11:10];
          cw_r      <= w_sel[9:8];
          chfirst_r <= (w_sel[9:8] == 2'd2) && (gbit(b_sel[5:4]) > gbit(b_sel[7:6]));
          diff_r    <= addr_r - {o_sel[23:4], {LSH{1'b0}}};
          skt_ways  <= 4'd1 << w_sel[11:10];
          chn_ways  <= 3'(w_sel[9:8]) + 3'd1;
          step_r    <= 1'b0;
          state     <= S_STEP;
        end
        S_STEP: if (use_div) begin
          dv_r  <= shr;
          rm_r  <= 2'd0;
          cnt_r <= NW'(AW - 1);
          state <= S_DIV;
        end else if (!step_r) begin
          acc_r  <= pow_res;
          step_r <= 1'b1;
        end else begin
          chan_addr <= pow_res;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_DIV: begin
          dv_r  <= div_q;
          rm_r  <= drm;
          cnt_r <= cnt_r - 1'b1;
          if (cnt_r == '0) begin
            if (!step_r) begin
              acc_r  <= div_res;
              step_r <= 1'b1;
              state  <= S_STEP;
            end else begin
              chan_addr <= div_res;
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r4_ways_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !miss) |-> ($countones(skt_ways) == 1 && chn_ways != 3'd0 && chn_ways <= 3'd4));
  a_r7_div_rem: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIV) |-> (rm_r < 2'd3));
  a_r3_miss_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && miss) |-> (chan_addr == '0));
endmodule

// File: tb/test_chan_ilv_remover.sv
`timescale 1ns/1ps
module test_chan_ilv_remover;
  localparam logic [63:0] M46 = (64'd1 << 46) - 64'd1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_kind = 0; logic cfg_ctrl = 0;
  logic [1:0] cfg_chan = 0; logic [2:0] cfg_rule = 0; logic [31:0] cfg_data = 0;
  logic start = 0; logic [45:0] sys_addr = 0; logic ctrl_sel = 0; logic [1:0] chan_sel = 0;
  logic busy, done, miss; logic [45:0] chan_addr; logic [3:0] skt_ways; logic [2:0] chn_ways;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  chan_ilv_remover i_chan_ilv_remover (.*);

  logic [31:0] m_base [2][8];
  logic [31:0] m_way  [2][8];
  logic [31:0] m_ofs  [2][3][8];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gt(input logic [1:0] g);
    case (g) 2'd0: return 6; 2'd1: return 8; 2'd2: return 12; default: return 30; endcase
  endfunction

  function automatic logic [63:0] ilv(input logic [63:0] x, input int s, input int w, input logic [63:0] l);
    logic [63:0] m = (64'd1 << s) - 64'd1;
    return ((((x >> s) / 64'(w)) << s) | (l & m)) & M46;
  endfunction

  function automatic logic [31:0] mk_base(input logic [19:0] b, input logic [1:0] sg, input logic [1:0] cg);
    return {b, 4'h0, cg, sg, 4'h0};
  endfunction
  function automatic logic [31:0] mk_way(input logic [19:0] l, input logic [1:0] sl, input logic [1:0] cw1);
    return {l, sl, cw1, 8'h00};
  endfunction
  function automatic logic [31:0] mk_off(input logic [19:0] o);
    return {8'h00, o, 4'h0};
  endfunction

  task automatic cfg(input logic [1:0] kind, input bit c, input logic [1:0] ch, input logic [2:0] r, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_kind = kind; cfg_ctrl = c; cfg_chan = ch; cfg_rule = r; cfg_data = d;
    if (kind == 2'd0) m_base[c][r] = d;
    else if (kind == 2'd1) m_way[c][r] = d;
    else if (kind == 2'd2 && ch < 2'd3) m_ofs[c][ch][r] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(input logic [45:0] a, input bit c, input logic [1:0] ch, input bit dbl, input string req);
    logic [63:0] ea, off, d, t; bit ms = 1; int sw = 0, cw = 0, lat = 1, n = 0, idx = -1;
    for (int i = 7; i >= 0; i--)
      if ((64'(m_base[c][i][31:12]) << 26) <= 64'(a) &&
          64'(a) <= ((64'(m_way[c][i][31:12]) << 26) | 64'h3FFFFFF)) idx = i;
    ea = 0;
    if (idx >= 0) begin
      int sg, cg;
      ms = 0;
      sw = 1 << m_way[c][idx][11:10];
      cw = int'(m_way[c][idx][9:8]) + 1;
      sg = gt(m_base[c][idx][5:4]);
      cg = gt(m_base[c][idx][7:6]);
      off = (ch < 2'd3) ? (64'(m_ofs[c][ch][idx][23:4]) << 26) : 64'd0;
      d = (64'(a) - off) & M46;
      if (cw == 3 && sg > cg) begin
        t = ilv(d, cg, cw, d);
        ea = ilv(t, sg, sw, t);
      end else begin
        t = ilv(d, sg, sw, 64'(a));
        ea = ilv(t, cg, cw, 64'(a));
      end
      lat = (cw == 3) ? 49 : 3;
    end
    @(negedge clk);
    sys_addr = a; ctrl_sel = c; chan_sel = ch; start = 1;
    forever begin
      @(negedge clk);
      start = dbl && n == 1;
      if (start) sys_addr = a ^ 46'h2A5;
      chk(done == (n == lat), "R9 done timing", 64'(done), 64'(n == lat));
      chk(busy == (n < lat), "R9 busy", 64'(busy), 64'(n < lat));
      if (n == lat) begin
        chk(miss == ms, {req, " miss"}, 64'(miss), 64'(ms));
        chk(64'(chan_addr) == ea, {req, " chan_addr"}, 64'(chan_addr), ea);
        chk(int'(skt_ways) == sw, {req, " skt_ways"}, 64'(skt_ways), 64'(sw));
        chk(int'(chn_ways) == cw, {req, " chn_ways"}, 64'(chn_ways), 64'(cw));
        break;
      end
      n++;
      if (n > 120) begin
        chk(0, {req, " no done"}, 64'(n), 64'(lat));
        break;
      end
    end
  endtask

  initial begin
    m_base = '{default: '0}; m_way = '{default: '0}; m_ofs = '{default: '0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && miss == 0 && chan_addr == 0, "reset", 64'(chan_addr), 64'd0);

    cfg(0, 0, 0, 0, mk_base(0, 0, 0));   cfg(1, 0, 0, 0, mk_way(3, 1, 0));
    cfg(0, 0, 0, 1, mk_base(4, 2, 0));   cfg(1, 0, 0, 1, mk_way(7, 0, 2));
    cfg(0, 0, 0, 2, mk_base(8, 0, 1));   cfg(1, 0, 0, 2, mk_way(11, 1, 2));
    cfg(0, 0, 0, 3, mk_base(12, 3, 2));  cfg(1, 0, 0, 3, mk_way(15, 3, 3));
    cfg(0, 0, 0, 4, mk_base(14, 1, 1));  cfg(1, 0, 0, 4, mk_way(20, 0, 1));
    cfg(0, 0, 0, 5, mk_base(24, 0, 0));  cfg(1, 0, 0, 5, mk_way(23, 0, 0));
    cfg(2, 0, 1, 0, mk_off(1));
    cfg(2, 0, 0, 1, mk_off(2));
    cfg(2, 0, 2, 2, mk_off(3));
    cfg(0, 1, 0, 0, mk_base(0, 1, 2));   cfg(1, 1, 0, 0, mk_way(20'h3F, 2, 1));
    cfg(2, 1, 0, 0, mk_off(20'h10));

    run(46'h123456, 0, 0, 0, "R4 two socket ways");
    run(46'h123456, 0, 1, 0, "R6 offset wrap");
    run((46'd5 << 26) | 46'h3ABCDE, 0, 0, 0, "R7 channel first");
    run((46'd9 << 26) | 46'h2F1234, 0, 2, 0, "R8 socket first");
    run((46'd13 << 26) | 46'h2ABCDEF, 0, 0, 0, "R5 coarse granularity");
    run(46'd14 << 26, 0, 0, 0, "R2 overlap priority");
    run((46'd17 << 26) | 46'h777, 0, 0, 0, "R2 second rule");
    run((46'd4 << 26) - 46'd1, 0, 0, 0, "R2 limit inclusive");
    run(46'd4 << 26, 0, 0, 0, "R2 base inclusive");
    run((46'd24 << 26) | 46'd5, 0, 0, 0, "R3 miss");
    run(46'h123456, 1, 0, 0, "R10 other controller");
    run((46'h3F << 26) | 46'h3FFFFFF, 1, 0, 0, "R10 top of range");
    run((46'd5 << 26) | 46'h1234, 0, 0, 1, "R9 start while busy");
    run(46'h0A5A5A, 0, 0, 1, "R9 start while busy fast");

    cfg(3, 0, 0, 0, 32'hFFFF_FFFF);
    cfg(2, 0, 3, 0, mk_off(20'h5));
    run(46'h123456, 0, 0, 0, "R1 ignored writes");
    cfg(1, 0, 0, 0, mk_way(3, 0, 3));
    run(46'h3456789, 0, 0, 0, "R1 rewrite wayness");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule